// File: doc/BRIEF.md
# Conversion Cycle Sequencer

This block times one measurement cycle of a multi-channel time digitizer. A valid start opens a conversion period of fixed length, counted in system clocks, that does not depend on the interval being measured. While the period runs the block reports busy. When it ends, a one-cycle completion pulse is produced and a service-request status bit is set. The status bit reaches the request output only while a separate enable latch is set.

A fast clear can abort the cycle, but only during an early window at the start of the period. The abort returns the unit to ready at the next clock edge and never sets the status bit. Once the window has passed, clear is ignored and the cycle always runs to completion. After completion the unit stays busy until software clears the status bit, so a new start cannot overwrite results that have not been read. There is no data path here, so every pin is a plain control or status level or a strobe. The default counts, 7000 for the window and 9000 for the period, give 70 µs and 90 µs at a 100 MHz clock.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, busy, completion pulse, status bit, request and the enable latch are all 0.
- R2: A start sampled while not busy makes busy 1 from the next edge. This holds even when a fast clear is sampled in the same cycle, because a clear has no effect while idle.
- R3: Count the edge that accepts the start as edge 0. The completion pulse and the status bit appear together after edge CYCLE_TICKS, and busy stays 1 from edge 0 through that point.
- R4: A fast clear sampled on edge k, with 1 <= k <= ABORT_TICKS, drops busy after that edge. The status bit stays 0 and no completion pulse follows.
- R5: A fast clear sampled on edge k, with ABORT_TICKS < k <= CYCLE_TICKS, is ignored and the cycle completes on time.
- R6: A start sampled while busy (converting or holding) is ignored. The timer keeps its count and the start is not remembered afterwards.
- R7: After completion, busy and the status bit stay 1 until a status-clear strobe is sampled. They both go to 0 after that edge.
- R8: The request output equals the status bit AND the enable latch. The enable-set strobe sets the latch and the enable-clear strobe clears it, and clear wins when both are sampled together.
- R9: A status-clear strobe during conversion, and a fast clear during the hold after completion, have no effect.
- R10: The completion pulse is high for exactly one cycle per completed conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Valid start strobe |
| fclr_i | input | 1 | Fast clear (abort) strobe |
| lam_en_set_i | input | 1 | Enable-latch set strobe |
| lam_en_clr_i | input | 1 | Enable-latch clear strobe |
| lam_clr_i | input | 1 | Status-bit clear strobe, which also releases busy after completion |
| busy_o | output | 1 | Unit is converting or holding unread results |
| conv_done_o | output | 1 | One-cycle completion pulse |
| lam_stat_o | output | 1 | Service-request status bit |
| lam_req_o | output | 1 | Status bit gated by the enable latch |

## Verification
The bench builds the block with ABORT_TICKS=5 and CYCLE_TICKS=9. Both edges of the abort window (the last honoured clear and the first ignored one), the clear on the final conversion cycle and full cycles are therefore only a few clocks long. This lets directed runs of both boundaries and several thousand random cycles of overlapping strobes fit easily. The short counts make re-entry right after an abort, and a start arriving during the hold state, happen many times.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/seq_timer.sv
// Cycle timer: counts clocks of the conversion period and flags the
// abort window and the last cycle.
module seq_timer #(
  parameter int ABORT_TICKS = 7000,
  parameter int CYCLE_TICKS = 9000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic in_window_o,
  output logic at_end_o
);
  localparam int CNT_W = (CYCLE_TICKS > 2) ? $clog2(CYCLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(ABORT_TICKS);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(CYCLE_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign in_window_o = (cnt_q < WIN_END);
  assign at_end_o    = (cnt_q == LAST);
endmodule

// File: rtl/seq_fsm.sv
// Cycle control: idle -> converting -> holding results.
module seq_fsm
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fclr_i,
  input  logic lam_clr_i,
  input  logic in_window_i,
  input  logic at_end_i,
  output logic restart_o,
  output logic run_o,
  output logic finish_o,
  output logic drop_o,
  output logic busy_o,
  output logic done_o
);
  seq_state_e st_q, st_d;
  logic take, abort, finish, drop;
  logic done_q;

  always_comb begin
    take   = (st_q == ST_IDLE) && start_i;
    abort  = (st_q == ST_CONV) && fclr_i && in_window_i;
    finish = (st_q == ST_CONV) && at_end_i && !abort;
    drop   = (st_q == ST_HOLD) && lam_clr_i;
    st_d   = st_q;
    if (take)        st_d = ST_CONV;
    else if (abort)  st_d = ST_IDLE;
    else if (finish) st_d = ST_HOLD;
    else if (drop)   st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
    end
  end

  assign restart_o = take;
  assign run_o     = (st_q == ST_CONV);
  assign finish_o  = finish;
  assign drop_o    = drop;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
endmodule

// File: rtl/seq_lam.sv
// Service-request status bit and its enable latch.
module seq_lam (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  output logic stat_o,
  output logic req_o
);
  logic stat_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (set_i)      stat_q <= 1'b1;
      else if (clr_i) stat_q <= 1'b0;
      if (en_clr_i)      en_q <= 1'b0;
      else if (en_set_i) en_q <= 1'b1;
    end
  end

  assign stat_o = stat_q;
  assign req_o  = stat_q & en_q;
endmodule

// File: rtl/conv_sequencer.sv
// Fixed-period conversion sequencer with an early abort window.
module conv_sequencer #(
  parameter int ABORT_TICKS = 7000,
  parameter int CYCLE_TICKS = 9000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fclr_i,
  input  logic lam_en_set_i,
  input  logic lam_en_clr_i,
  input  logic lam_clr_i,
  output logic busy_o,
  output logic conv_done_o,
  output logic lam_stat_o,
  output logic lam_req_o
);
  logic restart, run, in_window, at_end, finish, drop;

  seq_timer #(
    .ABORT_TICKS(ABORT_TICKS),
    .CYCLE_TICKS(CYCLE_TICKS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart),
    .run_i      (run),
    .in_window_o(in_window),
    .at_end_o   (at_end)
  );

  seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .fclr_i     (fclr_i),
    .lam_clr_i  (lam_clr_i),
    .in_window_i(in_window),
    .at_end_i   (at_end),
    .restart_o  (restart),
    .run_o      (run),
    .finish_o   (finish),
    .drop_o     (drop),
    .busy_o     (busy_o),
    .done_o     (conv_done_o)
  );

  seq_lam u_lam (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (finish),
    .clr_i   (drop),
    .en_set_i(lam_en_set_i),
    .en_clr_i(lam_en_clr_i),
    .stat_o  (lam_stat_o),
    .req_o   (lam_req_o)
  );
endmodule

// File: rtl/conv_sequencer_chk.sv
// Port-level checker; keeps its own age counter since the accepted start.
module conv_sequencer_chk #(
  parameter int ABORT_TICKS = 7000,
  parameter int CYCLE_TICKS = 9000
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic fclr_i,
  input logic lam_en_set_i,
  input logic lam_en_clr_i,
  input logic lam_clr_i,
  input logic busy_o,
  input logic conv_done_o,
  input logic lam_stat_o,
  input logic lam_req_o
);
  localparam int AGE_W = $clog2(CYCLE_TICKS + 1);
  localparam logic [AGE_W-1:0] WIN  = AGE_W'(ABORT_TICKS);
  localparam logic [AGE_W-1:0] FULL = AGE_W'(CYCLE_TICKS);

  logic [AGE_W-1:0] age_q;
  logic converting, early;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                age_q <= '0;
    else if (!busy_o)                          age_q <= '0;
    else if (!lam_stat_o && (age_q != FULL))   age_q <= age_q + AGE_W'(1);
  end

  assign converting = busy_o && !lam_stat_o;
  assign early      = (age_q < WIN);

  a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> busy_o);
  a_r3_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_o |-> (age_q == FULL) && lam_stat_o && busy_o);
  a_r3_not_late: assert property (@(posedge clk) disable iff (!rst_n)
    converting |-> (age_q < FULL));
  a_r4_early_clear_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    converting && fclr_i && early |=> !busy_o && !lam_stat_o);
  a_r4_idle_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !lam_stat_o);
  a_r5_late_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    converting && fclr_i && !early |=> busy_o);
  a_r7_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && lam_stat_o && !lam_clr_i |=> busy_o && lam_stat_o);
  a_r7_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && lam_stat_o && lam_clr_i |=> !busy_o && !lam_stat_o);
  a_r8_req_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    lam_req_o |-> lam_stat_o);
  a_r8_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lam_en_clr_i |=> !lam_req_o);
  a_r8_enable_passes: assert property (@(posedge clk) disable iff (!rst_n)
    lam_en_set_i && !lam_en_clr_i && lam_stat_o && !lam_clr_i |=> lam_req_o);
  a_r9_status_clear_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    converting && lam_clr_i && !(fclr_i && early) |=> busy_o);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_o |=> !conv_done_o);
endmodule

bind conv_sequencer conv_sequencer_chk #(
  .ABORT_TICKS(ABORT_TICKS),
  .CYCLE_TICKS(CYCLE_TICKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .fclr_i      (fclr_i),
  .lam_en_set_i(lam_en_set_i),
  .lam_en_clr_i(lam_en_clr_i),
  .lam_clr_i   (lam_clr_i),
  .busy_o      (busy_o),
  .conv_done_o (conv_done_o),
  .lam_stat_o  (lam_stat_o),
  .lam_req_o   (lam_req_o)
);

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
  localparam int ABORT = 5;
  localparam int CYC   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, fclr_i = 1'b0, lam_en_set_i = 1'b0;
  logic lam_en_clr_i = 1'b0, lam_clr_i = 1'b0;
  logic busy_o, conv_done_o, lam_stat_o, lam_req_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int n;

  always #5 clk = ~clk;

  conv_sequencer #(.ABORT_TICKS(ABORT), .CYCLE_TICKS(CYC)) u_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fclr_i(fclr_i),
    .lam_en_set_i(lam_en_set_i), .lam_en_clr_i(lam_en_clr_i),
    .lam_clr_i(lam_clr_i), .busy_o(busy_o), .conv_done_o(conv_done_o),
    .lam_stat_o(lam_stat_o), .lam_req_o(lam_req_o)
  );

  // Behavioural reference: age counts edges since the accepted start.
  int m_busy = 0, m_age = 0, m_lam = 0, m_en = 0, m_done = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_age = 0; m_lam = 0; m_en = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (start_i) begin m_busy = 1; m_age = 0; end
      end else if (m_lam == 0) begin
        if (fclr_i && m_age < ABORT) m_busy = 0;
        else if (m_age == CYC - 1) begin m_lam = 1; m_done = 1; end
        else m_age++;
      end else if (lam_clr_i) begin
        m_lam = 0; m_busy = 0;
      end
      if (lam_en_clr_i) m_en = 0;
      else if (lam_en_set_i) m_en = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 busy vs model", int'(busy_o), m_busy);
      chk("R10 conv_done vs model", int'(conv_done_o), m_done);
      chk("R3 lam_stat vs model", int'(lam_stat_o), m_lam);
      chk("R8 lam_req vs model", int'(lam_req_o), (m_lam != 0 && m_en != 0) ? 1 : 0);
    end
  end

  task automatic drive(input bit s, input bit f, input bit es, input bit ec, input bit lc);
    @(negedge clk);
    start_i = s; fclr_i = f; lam_en_set_i = es; lam_en_clr_i = ec; lam_clr_i = lc;
  endtask

  task automatic idle(input int cnt);
    repeat (cnt) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // Returns CYC+1 when done seen at the expected call, 0 on abort.
  task automatic run_cycle(input int f_age, input int s_age, input int l_age, output int calls);
    calls = -1;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int j = 1; j <= 4 * CYC; j++) begin
      drive(j - 1 == s_age, j - 1 == f_age, 1'b0, 1'b0, j - 1 == l_age);
      if (conv_done_o) begin calls = j; break; end
      if (!busy_o) begin calls = 0; break; end
    end
    start_i = 1'b0; fclr_i = 1'b0; lam_clr_i = 1'b0;
  endtask

  task automatic release_unit();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(1);
    chk("R7 status clear releases busy", int'(busy_o), 0);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 conv_done in reset", int'(conv_done_o), 0);
    chk("R1 lam_stat in reset", int'(lam_stat_o), 0);
    chk("R1 lam_req in reset", int'(lam_req_o), 0);
    rst_n = 1'b1;
    idle(2);

    // Normal cycle, enable latch still off
    run_cycle(-1, -1, -1, n);
    chk("R3 cycle length", n, CYC + 1);
    chk("R3 status set at completion", int'(lam_stat_o), 1);
    chk("R8 request gated while disabled", int'(lam_req_o), 0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 completion pulse one cycle", int'(conv_done_o), 0);
    idle(1);
    chk("R8 request when enabled", int'(lam_req_o), 1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(1);
    chk("R8 disable wins over enable", int'(lam_req_o), 0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    idle(1);
    chk("R8 request re-enabled", int'(lam_req_o), 1);

    // Clear and start during hold
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(2);
    chk("R9 fast clear ignored in hold", int'(busy_o), 1);
    chk("R9 status kept in hold", int'(lam_stat_o), 1);
    release_unit();
    chk("R7 status cleared", int'(lam_stat_o), 0);
    idle(2);
    chk("R6 start in hold not remembered", int'(busy_o), 0);

    // Aborts inside the window
    run_cycle(0, -1, -1, n);
    chk("R4 abort on first cycle", n, 0);
    idle(CYC + 3);
    chk("R4 no status after abort", int'(lam_stat_o), 0);
    chk("R4 stays idle after abort", int'(busy_o), 0);
    run_cycle(ABORT - 1, -1, -1, n);
    chk("R4 abort on last window cycle", n, 0);
    chk("R4 status clear after late-window abort", int'(lam_stat_o), 0);

    // Clears past the window
    run_cycle(ABORT, -1, -1, n);
    chk("R5 clear just past window ignored", n, CYC + 1);
    release_unit();
    run_cycle(CYC - 1, -1, -1, n);
    chk("R5 clear on final cycle ignored", n, CYC + 1);
    release_unit();

    // Start during conversion
    run_cycle(-1, 3, -1, n);
    chk("R6 start during conversion ignored", n, CYC + 1);
    release_unit();

    // Status clear during conversion
    run_cycle(-1, -1, 2, n);
    chk("R9 status clear in conversion ignored", n, CYC + 1);
    chk("R9 status set after ignored clear", int'(lam_stat_o), 1);
    release_unit();

    // Start with clear while idle
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R2 start taken with idle clear", int'(busy_o), 1);
    idle(CYC + 1);
    chk("R2 cycle after idle clear completes", int'(lam_stat_o), 1);
    release_unit();

    // Random strobes, compared each cycle against the model
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 8) == 0, ($urandom % 6) == 0, ($urandom % 10) == 0,
            ($urandom % 14) == 0, ($urandom % 9) == 0);
    end
    idle(2);

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1-R10 actual=running expected=finished");
      finished = 1'b1;
      report();
      $finish;
    end
  end
endmodule